// File: doc/BRIEF.md
# Shared HDLC Channel Enable Generator

This block lets a single HDLC controller serve up to sixteen line channels carried on one TDM stream. It watches a frame strobe, a bit-valid strobe and the current timeslot and bit position. From these it drives two clock-enable strobes, one for transmit and one for receive. Each strobe is high only during the chosen channel's bit positions. The controller's bit clock is gated with these strobes, so the controller sees a continuous serial stream made only of that channel's bits.

Software picks the next transmit channel by writing a 4-bit channel number and a half-select bit. The value waits in a pending register and moves to the active selection at the next frame boundary. A ready flag shows when the pending slot is free for another write. The receive side uses its own selection, with the same timing. A receive selection is dropped when fifteen enabled receive bits go by with no flag. The flag can come from the controller's flag detector or from a software strobe. The bits-per-frame setting (1 to 8) is captured at each frame boundary and applies to both strobes for the whole frame.

Top module: `shared_hdlc_cen`

## Requirements
- R1: After reset both strobes are low, both busy outputs are low, `ntx_ready` is high, and both selections are channel 0, half 0, inactive.
- R2: A transmit write while `ntx_ready` is high is accepted and `ntx_ready` is low from the next cycle. It stays low until the next frame boundary, where the pending value is taken and `ntx_ready` returns high.
- R3: A transmit write while `ntx_ready` is low is ignored. The channel enabled at the next boundary is the one written first.
- R4: A frame boundary is a cycle with both `frm_p` and `bit_en` high. A pending selection becomes active only at a boundary, and its enable window starts in that same cycle. The busy output rises in the following cycle.
- R5: A strobe is high exactly in cycles where `bit_en` is high, the selection is active, `slot_idx` equals the selected slot, and `bit_idx` is at most `bits_m1`. Bit index 0 is the first bit of the slot, so `bits_m1`+1 leading bits are enabled per frame.
- R6: The selected slot is half*16 + channel: half 0 picks slots 0 to 15 and half 1 picks slots 16 to 31.
- R7: `bits_m1` is sampled at each frame boundary and holds for the rest of that frame, even if the input changes mid-frame.
- R8: The receive strobe follows R4 to R7 with its own channel, half and write strobe. A receive write is always accepted and replaces any pending receive value.
- R9: An active receive selection is released after 15 enabled receive bits with no flag. The fifteenth bit is still enabled, and `rx_busy` is low from the next cycle.
- R10: `flag_seen` and `sw_flag` each restart the fifteen-bit timeout count, with the same effect.
- R11: Activating a new receive selection at a boundary restarts the timeout count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_p | input | 1 | Frame start marker, valid with `bit_en` |
| bit_en | input | 1 | Bit-valid strobe, one per serial bit |
| slot_idx | input | 5 | Current timeslot, 0 to 31 |
| bit_idx | input | 3 | Bit position within the slot, 0 first |
| bits_m1 | input | 3 | Enabled bits per frame minus one |
| ntx_wr | input | 1 | Write strobe for next transmit channel |
| ntx_chan | input | 4 | Next transmit channel number |
| ntx_half | input | 1 | Next transmit half select |
| rx_wr | input | 1 | Write strobe for receive channel |
| rx_chan | input | 4 | Receive channel number |
| rx_half | input | 1 | Receive half select |
| flag_seen | input | 1 | Flag detected by the controller |
| sw_flag | input | 1 | Software flag strobe |
| tx_cen | output | 1 | Transmit clock enable |
| rx_cen | output | 1 | Receive clock enable |
| ntx_ready | output | 1 | Pending transmit slot is free |
| tx_busy | output | 1 | Transmit selection active |
| rx_busy | output | 1 | Receive selection active |

## Verification
The bench targets the boundary cycle itself. A design that switched selection one cycle late would miss bit 0 of slot 0, or would mix two channels in one frame. It writes a second transmit channel while one is still pending, which catches a design that overwrites a pending value it should refuse. It changes the bit count in the middle of a frame to expose a rate that is not latched. It also runs receive windows of one bit per frame long enough to reach exactly fifteen. An off-by-one counter there would release a frame early or late. A timeout that ignored the software flag or a new activation would drop a channel that should stay live.

// File: rtl/hcg_pkg.sv
// Shared widths and types for the shared HDLC channel enable generator.
// Assumes a 32-slot frame of 8-bit slots split into two halves of 16.
package hcg_pkg;
    localparam int CHAN_W = 4;
    localparam int BIT_W  = 3;
    localparam int SLOT_W = CHAN_W + 1;
    localparam int NDIR   = 2;   // 0: transmit, 1: receive

    typedef struct packed {
        logic              half;
        logic [CHAN_W-1:0] chan;
    } sel_t;
endpackage

// File: rtl/hcg_chan_sel.sv
// Double-buffered channel selection. A write fills the pending register;
// at a frame boundary the pending value becomes active. The outputs give
// the selection in force this cycle, including on the boundary cycle.
// Assumes release_i is only raised by the owner of this selection.
module hcg_chan_sel
    import hcg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_go,
    input  logic wr_en,
    input  sel_t wr_sel,
    input  logic release_i,
    output logic act_eff,
    output sel_t sel_eff,
    output logic start,
    output logic pend_empty,
    output logic act_q
);
    sel_t pend_q;
    sel_t cur_q;
    logic pv_q;

    assign start      = frame_go & pv_q;
    assign act_eff    = act_q | start;
    assign sel_eff    = start ? pend_q : cur_q;
    assign pend_empty = ~pv_q;

    // Pending register: loaded by a write, emptied by a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv_q   <= 1'b0;
            pend_q <= '0;
        end else if (wr_en) begin
            pv_q   <= 1'b1;
            pend_q <= wr_sel;
        end else if (start) begin
            pv_q   <= 1'b0;
        end
    end

    // Active selection: taken at a boundary, dropped on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            cur_q <= '0;
        end else if (start) begin
            act_q <= 1'b1;
            cur_q <= pend_q;
        end else if (release_i) begin
            act_q <= 1'b0;
        end
    end

    p_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (act_q && cur_q == $past(pend_q)));
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(cur_q));
endmodule

// File: rtl/hcg_bit_window.sv
// Bit window decode: high on valid bits of the selected slot whose
// index lies within the first nbits_m1+1 bits (bit 0 first).
// Assumes slot_idx and bit_idx are stable while bit_en is high.
module hcg_bit_window
    import hcg_pkg::*;
(
    input  logic              act,
    input  sel_t              sel,
    input  logic              bit_en,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic [BIT_W-1:0]  nbits_m1,
    output logic              cen
);
    logic slot_hit;
    logic bit_hit;

    // Compare the stream position against the selection.
    always_comb begin
        slot_hit = (slot_idx == {sel.half, sel.chan});
        bit_hit  = (bit_idx <= nbits_m1);
        cen      = act & bit_en & slot_hit & bit_hit;
    end
endmodule

// File: rtl/hcg_rx_watchdog.sv
// Receive timeout: counts enabled receive bits since the last flag or
// activation and releases the selection on the TMO_BITS-th such bit.
// Assumes bit_on is the receive enable itself.
module hcg_rx_watchdog #(
    parameter int TMO_BITS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic flag,
    input  logic bit_on,
    output logic release_o
);
    localparam int CNT_W = $clog2(TMO_BITS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_BITS - 1);

    logic [CNT_W-1:0] cnt_q;

    assign release_o = bit_on & ~flag & ~restart & (cnt_q == LAST);

    // Bit counter cleared by flag, restart or release.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart | flag | release_o)
            cnt_q <= '0;
        else if (bit_on)
            cnt_q <= cnt_q + 1'b1;
    end

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(TMO_BITS));
    p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> (cnt_q == '0));
    p_restart_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));
endmodule

// File: rtl/shared_hdlc_cen.sv
// Top: transmit and receive clock-enable generator for one HDLC
// controller shared across 16 channels of a 32-slot stream. The two
// directions share selection and window logic built by generate;
// only the receive side has the flag timeout. Assumes frm_p marks slot 0
// bit 0 and is honoured only when bit_en is high.
module shared_hdlc_cen
    import hcg_pkg::*;
#(
    parameter int TMO_BITS = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_p,
    input  logic              bit_en,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic [BIT_W-1:0]  bits_m1,
    input  logic              ntx_wr,
    input  logic [CHAN_W-1:0] ntx_chan,
    input  logic              ntx_half,
    input  logic              rx_wr,
    input  logic [CHAN_W-1:0] rx_chan,
    input  logic              rx_half,
    input  logic              flag_seen,
    input  logic              sw_flag,
    output logic              tx_cen,
    output logic              rx_cen,
    output logic              ntx_ready,
    output logic              tx_busy,
    output logic              rx_busy
);
    logic             fb;
    logic [BIT_W-1:0] rate_q;
    logic [BIT_W-1:0] rate_eff;
    logic             rx_rel;

    logic wr_v   [NDIR];
    sel_t wsel_v [NDIR];
    logic rel_v  [NDIR];
    logic acte_v [NDIR];
    sel_t sele_v [NDIR];
    logic strt_v [NDIR];
    logic empt_v [NDIR];
    logic actq_v [NDIR];
    logic cen_v  [NDIR];

    assign fb        = frm_p & bit_en;
    assign rate_eff  = fb ? bits_m1 : rate_q;
    assign ntx_ready = empt_v[0];

    // Per-direction write, selection and release wiring.
    always_comb begin
        wr_v[0]   = ntx_wr & empt_v[0];
        wsel_v[0] = '{half: ntx_half, chan: ntx_chan};
        rel_v[0]  = 1'b0;
        wr_v[1]   = rx_wr;
        wsel_v[1] = '{half: rx_half, chan: rx_chan};
        rel_v[1]  = rx_rel;
    end

    // Bits-per-frame setting captured at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rate_q <= '0;
        else if (fb)
            rate_q <= bits_m1;
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        hcg_chan_sel i_sel (
            .clk        (clk),
            .rst_n      (rst_n),
            .frame_go   (fb),
            .wr_en      (wr_v[d]),
            .wr_sel     (wsel_v[d]),
            .release_i  (rel_v[d]),
            .act_eff    (acte_v[d]),
            .sel_eff    (sele_v[d]),
            .start      (strt_v[d]),
            .pend_empty (empt_v[d]),
            .act_q      (actq_v[d])
        );
        hcg_bit_window i_win (
            .act      (acte_v[d]),
            .sel      (sele_v[d]),
            .bit_en   (bit_en),
            .slot_idx (slot_idx),
            .bit_idx  (bit_idx),
            .nbits_m1 (rate_eff),
            .cen      (cen_v[d])
        );
    end

    hcg_rx_watchdog #(.TMO_BITS(TMO_BITS)) i_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (strt_v[1]),
        .flag      (flag_seen | sw_flag),
        .bit_on    (cen_v[1]),
        .release_o (rx_rel)
    );

    assign tx_cen  = cen_v[0];
    assign rx_cen  = cen_v[1];
    assign tx_busy = actq_v[0];
    assign rx_busy = actq_v[1];

    p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ntx_wr && ntx_ready) |=> !ntx_ready);
    p_busy_at_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(frm_p && bit_en));
    p_cen_on_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cen || rx_cen) |-> bit_en);
    p_rate_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(frm_p && bit_en) |=> $stable(rate_q));
    p_rx_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_busy) |-> $past(rx_cen));
endmodule

// File: tb/test_shared_hdlc_cen.sv
module test_shared_hdlc_cen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_p = 1'b0, bit_en = 1'b0;
    logic [4:0] slot_idx = '0;
    logic [2:0] bit_idx = '0, bits_m1 = '0;
    logic       ntx_wr = 1'b0, ntx_half = 1'b0, rx_wr = 1'b0, rx_half = 1'b0;
    logic [3:0] ntx_chan = '0, rx_chan = '0;
    logic       flag_seen = 1'b0, sw_flag = 1'b0;
    logic       tx_cen, rx_cen, ntx_ready, tx_busy, rx_busy;

    int checks = 0, errors = 0;
    int gaps = 0;
    bit done = 1'b0;

    // reference model state
    int m_tx_act, m_tx_sel, m_tx_pv, m_tx_pend;
    int m_rx_act, m_rx_sel, m_rx_pv, m_rx_pend;
    int m_rate, m_cnt;

    int ctx, crx, tslot;

    always #5 clk = ~clk;

    shared_hdlc_cen i_shared_hdlc_cen (
        .clk(clk), .rst_n(rst_n), .frm_p(frm_p), .bit_en(bit_en),
        .slot_idx(slot_idx), .bit_idx(bit_idx), .bits_m1(bits_m1),
        .ntx_wr(ntx_wr), .ntx_chan(ntx_chan), .ntx_half(ntx_half),
        .rx_wr(rx_wr), .rx_chan(rx_chan), .rx_half(rx_half),
        .flag_seen(flag_seen), .sw_flag(sw_flag),
        .tx_cen(tx_cen), .rx_cen(rx_cen), .ntx_ready(ntx_ready),
        .tx_busy(tx_busy), .rx_busy(rx_busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_en(input int act, input int sel, input int pv, input int pend);
        int a = act, s = sel, r = m_rate;
        if (frm_p && bit_en && pv != 0) begin a = 1; s = pend; end
        if (frm_p && bit_en) r = int'(bits_m1);
        return (a != 0 && bit_en && int'(slot_idx) == s && int'(bit_idx) <= r) ? 1 : 0;
    endfunction

    // stream position generator: 32 slots of 8 bits, optional bit gaps
    initial begin
        int pos = 0, gc = 0;
        forever begin
            @(posedge clk); #1;
            if (!rst_n) begin pos = 0; bit_en = 1'b0; end
            else begin
                if (bit_en) pos = (pos + 1) % 256;
                gc++;
                bit_en = (gaps != 0) ? (gc % 3 != 0) : 1'b1;
            end
            slot_idx = 5'(pos / 8);
            bit_idx  = 3'(pos % 8);
            frm_p    = (pos == 0);
        end
    end

    // behavioural reference model, updated on each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_tx_act = 0; m_tx_sel = 0; m_tx_pv = 0; m_tx_pend = 0;
            m_rx_act = 0; m_rx_sel = 0; m_rx_pv = 0; m_rx_pend = 0;
            m_rate = 0; m_cnt = 0;
        end else begin
            int fb, acc, rxen, rx_start;
            fb   = (frm_p && bit_en) ? 1 : 0;
            rxen = exp_en(m_rx_act, m_rx_sel, m_rx_pv, m_rx_pend);
            acc  = (ntx_wr && m_tx_pv == 0) ? 1 : 0;
            if (fb != 0 && m_tx_pv != 0) begin m_tx_act = 1; m_tx_sel = m_tx_pend; m_tx_pv = 0; end
            if (acc != 0) begin m_tx_pend = int'(ntx_half) * 16 + int'(ntx_chan); m_tx_pv = 1; end
            rx_start = (fb != 0 && m_rx_pv != 0) ? 1 : 0;
            if (rx_start != 0) begin m_rx_act = 1; m_rx_sel = m_rx_pend; m_rx_pv = 0; m_cnt = 0; end
            else if (flag_seen || sw_flag) m_cnt = 0;
            else if (rxen != 0) begin
                m_cnt++;
                if (m_cnt == 15) begin m_rx_act = 0; m_cnt = 0; end
            end
            if (rx_wr) begin m_rx_pend = int'(rx_half) * 16 + int'(rx_chan); m_rx_pv = 1; end
            if (fb != 0) m_rate = int'(bits_m1);
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R5 tx_cen", int'(tx_cen), exp_en(m_tx_act, m_tx_sel, m_tx_pv, m_tx_pend));
            check("R8 rx_cen", int'(rx_cen), exp_en(m_rx_act, m_rx_sel, m_rx_pv, m_rx_pend));
            check("R2 ntx_ready", int'(ntx_ready), (m_tx_pv == 0) ? 1 : 0);
            check("R4 tx_busy", int'(tx_busy), m_tx_act);
            check("R9 rx_busy", int'(rx_busy), m_rx_act);
        end
    end

    task automatic wr_tx(input int ch, input int hf);
        @(posedge clk); #1;
        ntx_wr = 1'b1; ntx_chan = 4'(ch); ntx_half = 1'(hf);
        @(posedge clk); #1;
        ntx_wr = 1'b0;
    endtask

    task automatic wr_rx(input int ch, input int hf);
        @(posedge clk); #1;
        rx_wr = 1'b1; rx_chan = 4'(ch); rx_half = 1'(hf);
        @(posedge clk); #1;
        rx_wr = 1'b0;
    endtask

    task automatic pulse_flag(input int use_sw);
        @(posedge clk); #1;
        if (use_sw != 0) sw_flag = 1'b1; else flag_seen = 1'b1;
        @(posedge clk); #1;
        sw_flag = 1'b0; flag_seen = 1'b0;
    endtask

    task automatic to_boundary();
        do @(negedge clk); while (!(frm_p && bit_en));
    endtask

    // count strobes over n frames, starting at a boundary negedge
    task automatic run_frames(input int n);
        int b = 0;
        ctx = 0; crx = 0; tslot = -1;
        while (1) begin
            if (tx_cen) begin ctx++; tslot = int'(slot_idx); end
            if (rx_cen) crx++;
            @(negedge clk);
            if (frm_p && bit_en) begin b++; if (b == n) break; end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 tx_cen", int'(tx_cen), 0);
        check("R1 rx_cen", int'(rx_cen), 0);
        check("R1 ntx_ready", int'(ntx_ready), 1);
        check("R1 busy", int'(tx_busy) + int'(rx_busy), 0);

        bits_m1 = 3'd7;
        wr_tx(3, 0);
        @(negedge clk);
        check("R2 ready low after write", int'(ntx_ready), 0);
        check("R4 not busy before boundary", int'(tx_busy), 0);
        wr_tx(9, 0);                       // refused: pending still full
        to_boundary();
        run_frames(1);
        check("R3 first channel kept", tslot, 3);
        check("R5 eight bits per frame", ctx, 8);
        check("R2 ready after transfer", int'(ntx_ready), 1);

        wr_tx(5, 1);
        to_boundary();
        run_frames(1);
        check("R6 upper half slot", tslot, 21);

        fork
            run_frames(1);
            begin repeat (4) @(posedge clk); #1 bits_m1 = 3'd2; end
        join
        check("R7 rate held mid-frame", ctx, 8);
        run_frames(1);
        check("R7 new rate next frame", ctx, 3);

        gaps = 1;
        to_boundary();
        run_frames(2);
        check("R5 with bit gaps", ctx, 6);
        gaps = 0;

        bits_m1 = 3'd0;
        wr_rx(2, 1);
        to_boundary();
        run_frames(16);
        check("R9 fifteen bits then release", crx, 15);
        check("R9 rx released", int'(rx_busy), 0);
        check("R8 tx one bit per frame", ctx, 16);

        wr_rx(2, 1);
        to_boundary();
        for (int k = 0; k < 4; k++) begin
            run_frames(5);
            pulse_flag(k % 2);
            to_boundary();
        end
        check("R10 flags keep rx alive", int'(rx_busy), 1);

        run_frames(10);
        wr_rx(2, 1);
        to_boundary();
        run_frames(10);
        check("R11 reactivation restarts count", int'(rx_busy), 1);
        run_frames(6);
        check("R9 released after restart", int'(rx_busy), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule